// File: doc/BRIEF.md
# Seven-segment digit chain decoder with zero suppression

The block turns a row of 4-bit decimal digits into drive patterns for a row of seven-segment displays. Each digit position has a nibble store that either follows its input or freezes the last captured value. The decoder draws the shapes for 0 to 9 and leaves the display dark for codes 10 to 15. Three shared controls act on every position: a dark-all input, a lamp check that lights every segment, and a zero-suppression input that enters at the most significant position.

Zero suppression ripples downward. A position goes dark when its incoming suppress line is low and its shown nibble is zero. It then drives its outgoing suppress line low so the next lower position may also go dark. The first nonzero position shows its digit and stops the ripple, so inner zeros stay visible. Parameters pick the output polarity for common-cathode or common-anode displays, and whether 6 and 9 carry their tail segment.

Top module: `bcd7_chain`

## Requirements
- R1: Segment bit k of a digit's 7-bit field drives segment a+k (bit 0 = a, bit 6 = g). Codes 0 to 9 give the standard patterns: 0 = abcdef, 1 = bc, 2 = abdeg, 3 = abcdg, 4 = bcfg, 5 = acdfg, 7 = abc, 8 = all seven.
- R2: With TAILS=1, 6 is acdefg and 9 is abcdfg. With TAILS=0, 6 is cdefg and 9 is abcfg.
- R3: A shown nibble of 10 to 15 leaves all seven segments of that digit off.
- R4: While blank_n is 0, every segment of every digit is off, whatever the data, lamp_test or suppress inputs.
- R5: While blank_n is 1 and lamp_test is 1, every segment of every digit is on, overriding data and zero suppression.
- R6: A digit is dark when its incoming suppress line is low and its shown nibble is 0. Its outgoing suppress line is low exactly in that case.
- R7: Digit i occupies bcd_in[4i+3:4i] and seg_out[7i+6:7i], with digit 0 least significant. rbi_n feeds the most significant digit. Each digit's outgoing suppress line feeds the next lower digit. rbo_n is the outgoing line of digit 0.
- R8: While hold is 0, each digit shows its bcd_in nibble directly and captures it on every rising clock edge. While hold is 1, it shows the nibble captured at the last edge where hold was 0.
- R9: With ACTIVE_LOW=0, a lit segment is 1. With ACTIVE_LOW=1, every segment bit is inverted.
- R10: Reset clears every stored nibble to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the nibble stores |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | 1 freezes the stored nibbles, 0 passes the inputs through |
| blank_n | input | 1 | Active-low dark-all control |
| lamp_test | input | 1 | Lights every segment |
| rbi_n | input | 1 | Zero-suppress input at the most significant digit |
| bcd_in | input | 4*DIGITS | Packed digit nibbles, digit 0 lowest |
| seg_out | output | 7*DIGITS | Packed segment fields, digit 0 lowest |
| rbo_n | output | 1 | Zero-suppress output of the least significant digit |

## Verification
The hardest case to reach is a suppress ripple that has to cross several positions of stored rather than live nibbles, because it depends on the hold history, the suppress input and the data all at once. The bench loads values such as 00000077, 00700700 and all zeros, then freezes them while the live inputs change to unrelated values. It then toggles the suppress input and lamp check and compares every digit against a behavioural model on every clock. A second instance with inverted polarity and no tails runs on the same stimulus.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;
  typedef logic [6:0] seg_t;  // bit 0 = a ... bit 6 = g

  function automatic seg_t shape_of(input logic [3:0] nib, input logic tails);
    seg_t s;
    case (nib)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = tails ? 7'h7D : 7'h7C;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = tails ? 7'h6F : 7'h67;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/bcd7_hold.sv
module bcd7_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stored;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stored <= '0;
    else if (!hold) stored <= d;
  end

  assign q = hold ? stored : d;

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> $stable(q));
endmodule

// File: rtl/bcd7_digit.sv
module bcd7_digit
  import bcd7_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b0,
  parameter bit TAILS      = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       blank_n,
  input  logic       lamp_test,
  input  logic       rbi_n,
  input  logic [3:0] nib_in,
  output seg_t       seg,
  output logic       rbo_n
);
  localparam seg_t OFF_PAT = ACTIVE_LOW ? 7'h7F : 7'h00;
  localparam seg_t ON_PAT  = ACTIVE_LOW ? 7'h00 : 7'h7F;

  logic [3:0] shown;
  logic       zero_blank;
  seg_t       lit;

  bcd7_hold #(.W(4)) u_hold (
    .clk(clk), .rst_n(rst_n), .hold(hold), .d(nib_in), .q(shown)
  );

  assign zero_blank = !rbi_n && (shown == 4'd0);
  assign rbo_n      = !zero_blank;

  always_comb begin
    if (!blank_n)        lit = 7'h00;
    else if (lamp_test)  lit = 7'h7F;
    else if (zero_blank) lit = 7'h00;
    else                 lit = shape_of(shown, TAILS);
  end

  assign seg = ACTIVE_LOW ? ~lit : lit;

  a_r4_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> seg == OFF_PAT);
  a_r5_lamp: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && lamp_test) |-> seg == ON_PAT);
  a_r3_no_glyph: assert property (@(posedge clk) disable iff (!rst_n)
    (!lamp_test && shown > 4'd9) |-> seg == OFF_PAT);
  a_r6_ripple: assert property (@(posedge clk) disable iff (!rst_n)
    !rbo_n |-> (!rbi_n && shown == 4'd0));
  a_r6_suppressed_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (!rbo_n && !lamp_test) |-> seg == OFF_PAT);
endmodule

// File: rtl/bcd7_chain.sv
module bcd7_chain #(
  parameter int DIGITS     = 8,
  parameter bit ACTIVE_LOW = 1'b0,
  parameter bit TAILS      = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold,
  input  logic                blank_n,
  input  logic                lamp_test,
  input  logic                rbi_n,
  input  logic [4*DIGITS-1:0] bcd_in,
  output logic [7*DIGITS-1:0] seg_out,
  output logic                rbo_n
);
  localparam int NW = 4;
  localparam int SW = 7;

  logic [DIGITS:0] ripple_n;  // ripple_n[i+1] enters digit i

  assign ripple_n[DIGITS] = rbi_n;
  assign rbo_n            = ripple_n[0];

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    bcd7_digit #(.ACTIVE_LOW(ACTIVE_LOW), .TAILS(TAILS)) u_digit (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (hold),
      .blank_n   (blank_n),
      .lamp_test (lamp_test),
      .rbi_n     (ripple_n[i+1]),
      .nib_in    (bcd_in[NW*i +: NW]),
      .seg       (seg_out[SW*i +: SW]),
      .rbo_n     (ripple_n[i])
    );
  end

  // R7: the chain cannot release suppression below a digit that kept it
  a_r7_chain_order: assert property (@(posedge clk) disable iff (!rst_n)
    (rbi_n && lamp_test == 1'b0) |-> rbo_n);
endmodule

// File: tb/bcd7_chain_bench.sv
`timescale 1ns/1ps
module bcd7_chain_bench;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold = 1'b0, blank_n = 1'b1, lamp_test = 1'b0, rbi_n = 1'b1;
  logic [4*N-1:0] bcd_in = '0;
  logic [7*N-1:0] seg_a, seg_b;
  logic rbo_a, rbo_b;

  int checks = 0, failures = 0;
  string tag = "R10";
  logic [3:0] ref_nib [N];

  always #4 clk = ~clk;

  bcd7_chain #(.DIGITS(N), .ACTIVE_LOW(1'b0), .TAILS(1'b1)) u_bcd7_chain (
    .clk(clk), .rst_n(rst_n), .hold(hold), .blank_n(blank_n),
    .lamp_test(lamp_test), .rbi_n(rbi_n), .bcd_in(bcd_in),
    .seg_out(seg_a), .rbo_n(rbo_a));

  bcd7_chain #(.DIGITS(N), .ACTIVE_LOW(1'b1), .TAILS(1'b0)) u_bcd7_chain_alt (
    .clk(clk), .rst_n(rst_n), .hold(hold), .blank_n(blank_n),
    .lamp_test(lamp_test), .rbi_n(rbi_n), .bcd_in(bcd_in),
    .seg_out(seg_b), .rbo_n(rbo_b));

  // reference nibble stores (R8, R10)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int i = 0; i < N; i++) ref_nib[i] <= 4'd0;
    else if (!hold) for (int i = 0; i < N; i++) ref_nib[i] <= bcd_in[4*i +: 4];
  end

  // per-segment digit membership masks, bit d set when digit d lights it
  function automatic logic [6:0] glyph(input int d, input bit tails);
    logic [9:0] m [7];
    logic [6:0] r;
    m[0] = 10'b1110101101 | (tails ? 10'b0001000000 : 10'b0);
    m[1] = 10'b1110011111;
    m[2] = 10'b1111111011;
    m[3] = 10'b0101101101 | (tails ? 10'b1000000000 : 10'b0);
    m[4] = 10'b0101000101;
    m[5] = 10'b1101110001;
    m[6] = 10'b1101111100;
    for (int k = 0; k < 7; k++) r[k] = (d <= 9) ? m[k][d] : 1'b0;
    return r;
  endfunction

  task automatic compare();
    logic rb;
    logic [7*N-1:0] ea, eb;
    rb = rbi_n;
    for (int i = N - 1; i >= 0; i--) begin
      int nv;
      bit zb;
      logic [6:0] la, lb;
      nv = hold ? int'(ref_nib[i]) : int'(bcd_in[4*i +: 4]);
      zb = (rb == 1'b0) && (nv == 0);
      rb = zb ? 1'b0 : 1'b1;
      if (!blank_n)       begin la = 7'h00; lb = 7'h00; end
      else if (lamp_test) begin la = 7'h7F; lb = 7'h7F; end
      else if (zb)        begin la = 7'h00; lb = 7'h00; end
      else begin la = glyph(nv, 1'b1); lb = glyph(nv, 1'b0); end
      ea[7*i +: 7] = la;
      eb[7*i +: 7] = ~lb;
    end
    checks++;
    if (seg_a !== ea || rbo_a !== rb) begin
      failures++;
      $display("FAIL %s main: seg=%h rbo=%b expected seg=%h rbo=%b", tag, seg_a, rbo_a, ea, rb);
    end
    checks++;
    if (seg_b !== eb || rbo_b !== rb) begin
      failures++;
      $display("FAIL %s R9 alt: seg=%h rbo=%b expected seg=%h rbo=%b", tag, seg_b, rbo_b, eb, rb);
    end
  endtask

  always @(negedge clk) if (rst_n) compare();

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    hold = 1'b1;
    bcd_in = 32'h99999999;
    step(3);
    tag = "R10";             // reset cleared stores: all digits show 0
    rst_n = 1'b1;
    step(3);

    tag = "R1_R2_R3";         // every code at every position, transparent
    hold = 1'b0;
    for (int d = 0; d < 16; d++) begin
      bcd_in = {N{d[3:0]}};
      step(2);
    end
    bcd_in = 32'h01234567; step(2);
    bcd_in = 32'h89ABCDEF; step(2);

    tag = "R6_R7";            // zero suppression across the chain
    rbi_n = 1'b0;
    bcd_in = 32'h00000077; step(2);
    bcd_in = 32'h00000000; step(2);
    bcd_in = 32'h10000000; step(2);
    bcd_in = 32'h00700700; step(2);
    bcd_in = 32'h000A0000; step(2);
    rbi_n = 1'b1;
    bcd_in = 32'h00000077; step(2);

    tag = "R5";               // lamp test beats data and suppression
    rbi_n = 1'b0; bcd_in = 32'h00000000; lamp_test = 1'b1; step(2);
    bcd_in = 32'hFFFF0000; step(2);

    tag = "R4";               // dark-all beats lamp test
    blank_n = 1'b0; step(2);
    lamp_test = 1'b0; bcd_in = 32'h88888888; step(2);
    blank_n = 1'b1;

    tag = "R8";               // freeze then change inputs
    rbi_n = 1'b1; bcd_in = 32'h12345678; step(1);
    hold = 1'b1; bcd_in = 32'h99999999; step(4);
    rbi_n = 1'b0; bcd_in = 32'h00000000; step(2);
    hold = 1'b0; bcd_in = 32'h00000077; step(1);
    hold = 1'b1; bcd_in = 32'h55555555; step(3);
    hold = 1'b0; step(2);

    tag = "R1_R6_R8_random";
    for (int k = 0; k < 600; k++) begin
      bcd_in = $urandom;
      if ($urandom_range(0, 2) == 0) bcd_in[31:16] = 16'h0000;
      hold      = ($urandom_range(0, 3) == 0);
      rbi_n     = $urandom_range(0, 1);
      lamp_test = ($urandom_range(0, 9) == 0);
      blank_n   = ($urandom_range(0, 9) != 0);
      step(1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule